// File: doc/BRIEF.md
# Three-Wire Register Control Slave

This block lets a host reach a bank of 128 eight-bit control registers over three wires: an active-low select, a serial clock and one data line that both sides share. Every transaction is sixteen serial clocks long. The host first sends a direction bit, then a seven-bit register number, and then either eight bits of write data or eight clock slots in which the slave returns the register contents. The slave only drives the shared line in the second half of a read. It does so through an output-enable, so the pad buffer can sit outside the block.

The three pins are oversampled by a faster fabric clock. A two-stage synchronizer and an edge detector turn them into single-cycle events. All frame decoding, the register storage and the pad drivers run on that fabric clock. An active-low power-down input returns the whole bank to its reset defaults. One bit in the bank gates the read path.

Top module: `tw_ctl_slave`

## Requirements
- R1: A frame is the direction bit, then the address A6..A0, then the data D7..D0, with the most significant bit first. Each bit is taken from the data line on a rising edge of the serial clock while select is low.
- R2: A direction bit of 1 is a write and 0 is a read. During a write frame the output-enable never asserts.
- R3: A write changes the addressed register only when select is released after exactly 16 rising clock edges. A later read of that address returns the written byte.
- R4: A frame released with fewer than 16 or more than 16 rising edges changes no register.
- R5: In a read, the output-enable asserts on the falling edge that follows the 8th rising edge, and D7 appears on the line at that point. Each later falling edge presents the next lower bit, so the host captures D7..D0 on rising edges 9 to 16.
- R6: Reads are enabled by bit 0 of register 00h, whose default value is 01h. While that bit is 0, the output-enable stays low for the whole frame.
- R7: The output-enable drops when select is released, and it is low whenever select is high.
- R8: Addresses 00h–19h, 1Ch–25h, 30h and 32h–4Fh read back their stored value. Every other address reads back as 00h.
- R9: While the power-down input is low, the output-enable is low and every register returns to its default: 01h at address 00h and 00h elsewhere.
- R10: Every output change appears after the third rising edge of the fabric clock following the pin edge that causes it. The first of those three edges is the one that samples the pin.
- R11: The bit counter clears while select is high, so a frame that follows an aborted one decodes from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that oversamples the serial pins |
| pwrdn_n | input | 1 | Power-down, active low, sampled on clk; restores defaults |
| ctl_csb | input | 1 | Serial select, active low |
| ctl_sck | input | 1 | Serial clock from the host |
| ctl_sdio_i | input | 1 | Data line as seen at the pad input |
| ctl_sdio_o | output | 1 | Data the slave drives during a read |
| ctl_sdio_oe | output | 1 | Pad output-enable for the data line |

## Verification
Each pin edge reaches the pad outputs after the third fabric clock edge that follows it. The turnaround after the eighth falling edge is therefore checked as still low two fabric cycles after the drive and high one cycle later. A register commit shows up only in the next read frame, so the bench checks it with a readback. The bench drives the pins on falling fabric edges and keeps a behavioural model whose pin history is delayed by the same two sampling stages. It compares the enable and the data on every falling edge. Host-side captures are taken five fabric cycles after each serial falling edge, well after the outputs have settled.

// File: rtl/tw_ctl_pkg.sv
package tw_ctl_pkg;

  // Direction field of the frame header.
  typedef enum logic {
    XFER_RD = 1'b0,
    XFER_WR = 1'b1
  } xfer_dir_e;

  // Single-cycle events derived from the synchronized pins.
  typedef struct packed {
    logic sck_rise;
    logic sck_fall;
    logic cs_rise;
    logic cs_low;
    logic din;
  } pin_evt_t;

  // Map of register numbers whose readback is meaningful.
  function automatic logic addr_readable(input int unsigned a);
    return (a <= 32'h19) ||
           (a >= 32'h1C && a <= 32'h25) ||
           (a == 32'h30) ||
           (a >= 32'h32 && a <= 32'h4F);
  endfunction

endpackage

// File: rtl/tws_pin_sync.sv
module tws_pin_sync
  import tw_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sck_i,
  input  logic     csb_i,
  input  logic     sdio_i,
  output pin_evt_t evt
);

  localparam int NSIG = 3;
  // Idle levels: clock high, select high, data low.
  localparam logic [NSIG-1:0] IDLE = 3'b011;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] stg [SYNC_STAGES];
  logic [NSIG-1:0] last;
  logic [NSIG-1:0] cur;

  assign raw = {sdio_i, csb_i, sck_i};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= IDLE;
        else     stg[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= IDLE;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign cur = stg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last <= IDLE;
    else     last <= cur;
  end

  always_comb begin
    evt.sck_rise = cur[0] & ~last[0];
    evt.sck_fall = ~cur[0] & last[0];
    evt.cs_rise  = cur[1] & ~last[1];
    evt.cs_low   = ~cur[1];
    evt.din      = cur[2];
  end

endmodule

// File: rtl/tws_frame.sv
module tws_frame
  import tw_ctl_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W,
  localparam int HDR_LEN   = 1 + ADDR_W,
  localparam int CNT_W     = $clog2(FRAME_LEN + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  pin_evt_t          evt,
  input  logic [DATA_W-1:0] rd_byte,
  input  logic              rd_allowed,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_LEN);

  logic [FRAME_LEN-1:0] shreg;
  logic [DATA_W-1:0]    obuf;
  logic                 hdr_read;
  logic                 full_write;

  // Once the header is in, its low bits hold the address and the bit above holds the direction.
  assign rd_addr    = shreg[ADDR_W-1:0];
  assign hdr_read   = (shreg[HDR_LEN-1] == XFER_RD);
  assign full_write = (bit_cnt == CNT_FULL) && (shreg[FRAME_LEN-1] == XFER_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      shreg   <= '0;
      obuf    <= '0;
      sdo     <= 1'b0;
      sdo_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (evt.cs_rise) begin
        // Release: commit a complete write, stop driving.
        if (full_write) begin
          wr_stb  <= 1'b1;
          wr_addr <= shreg[FRAME_LEN-2 -: ADDR_W];
          wr_data <= shreg[DATA_W-1:0];
        end
        bit_cnt <= '0;
        sdo_oe  <= 1'b0;
        sdo     <= 1'b0;
      end else if (!evt.cs_low) begin
        bit_cnt <= '0;
        sdo_oe  <= 1'b0;
      end else begin
        if (evt.sck_rise) begin
          shreg <= {shreg[FRAME_LEN-2:0], evt.din};
          if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
        end
        if (evt.sck_fall) begin
          if (bit_cnt == CNT_HDR && hdr_read && rd_allowed) begin
            sdo_oe <= 1'b1;
            sdo    <= rd_byte[DATA_W-1];
            obuf   <= {rd_byte[DATA_W-2:0], 1'b0};
          end else if (sdo_oe) begin
            sdo  <= obuf[DATA_W-1];
            obuf <= {obuf[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/tws_regbank.sv
module tws_regbank
  import tw_ctl_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int RDEN_ADDR = 0,
  parameter int RDEN_BIT  = 0,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_allowed
);

  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    logic [DATA_W-1:0] one;
    one = DATA_W'(1);
    return (idx == RDEN_ADDR) ? (one << RDEN_BIT) : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reg_default(i);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data    = addr_readable(32'(rd_addr)) ? mem[rd_addr] : '0;
  assign rd_allowed = mem[RDEN_ADDR][RDEN_BIT];

endmodule

// File: rtl/tw_ctl_slave.sv
module tw_ctl_slave
  import tw_ctl_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RDEN_ADDR   = 0,
  parameter int RDEN_BIT    = 0
) (
  input  logic clk,
  input  logic pwrdn_n,
  input  logic ctl_csb,
  input  logic ctl_sck,
  input  logic ctl_sdio_i,
  output logic ctl_sdio_o,
  output logic ctl_sdio_oe
);

  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);

  logic              rst;
  pin_evt_t          evt;
  logic [DATA_W-1:0] rd_byte;
  logic              rd_allowed;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic              ev_sck_fall;
  logic              ev_cs_rise;
  logic              ev_cs_low;

  assign rst         = ~pwrdn_n;
  assign ev_sck_fall = evt.sck_fall;
  assign ev_cs_rise  = evt.cs_rise;
  assign ev_cs_low   = evt.cs_low;

  tws_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sck_i  (ctl_sck),
    .csb_i  (ctl_csb),
    .sdio_i (ctl_sdio_i),
    .evt    (evt)
  );

  tws_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .rd_byte    (rd_byte),
    .rd_allowed (rd_allowed),
    .rd_addr    (rd_addr),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sdo        (ctl_sdio_o),
    .sdo_oe     (ctl_sdio_oe),
    .bit_cnt    (bit_cnt)
  );

  tws_regbank #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RDEN_ADDR (RDEN_ADDR),
    .RDEN_BIT  (RDEN_BIT)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_byte),
    .rd_allowed (rd_allowed)
  );

endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int CNT_W     = 5,
  parameter int FRAME_LEN = 16
) (
  input logic             clk,
  input logic             pwrdn_n,
  input logic             sdio_o,
  input logic             sdio_oe,
  input logic             sck_fall,
  input logic             cs_rise,
  input logic             cs_low,
  input logic             rd_allowed,
  input logic             wr_stb,
  input logic [CNT_W-1:0] bit_cnt
);

  // R7: releasing select ends the drive on the next cycle
  a_r7_release_ends_drive: assert property (@(posedge clk) disable iff (!pwrdn_n)
    cs_rise |=> !sdio_oe);

  // R7: select high keeps the line undriven
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!pwrdn_n)
    !cs_low |=> !sdio_oe);

  // R5: turnaround happens only on a serial falling edge
  a_r5_turn_on_fall: assert property (@(posedge clk) disable iff (!pwrdn_n)
    $rose(sdio_oe) |-> $past(sck_fall));

  // R5: the driven bit only moves on a serial falling edge
  a_r5_bit_held: assert property (@(posedge clk) disable iff (!pwrdn_n)
    (sdio_oe && $past(sdio_oe) && !$past(sck_fall)) |-> $stable(sdio_o));

  // R6: no turnaround while reads are disabled
  a_r6_gate: assert property (@(posedge clk) disable iff (!pwrdn_n)
    $rose(sdio_oe) |-> $past(rd_allowed));

  // R3: a commit strobe follows a select release
  a_r3_commit_on_release: assert property (@(posedge clk) disable iff (!pwrdn_n)
    wr_stb |-> $past(cs_rise));

  // R4: a release with a wrong bit count commits nothing
  a_r4_bad_len_dropped: assert property (@(posedge clk) disable iff (!pwrdn_n)
    (cs_rise && bit_cnt != CNT_W'(FRAME_LEN)) |=> !wr_stb);

endmodule

bind tw_ctl_slave tws_checker #(.CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN)) u_chk (
  .clk        (clk),
  .pwrdn_n    (pwrdn_n),
  .sdio_o     (ctl_sdio_o),
  .sdio_oe    (ctl_sdio_oe),
  .sck_fall   (ev_sck_fall),
  .cs_rise    (ev_cs_rise),
  .cs_low     (ev_cs_low),
  .rd_allowed (rd_allowed),
  .wr_stb     (wr_stb),
  .bit_cnt    (bit_cnt)
);

// File: tb/tb_tw_ctl_slave.sv
`timescale 1ns/1ps
module tb_tw_ctl_slave;

  logic clk = 1'b0;
  logic pwrdn_n = 1'b0;
  logic ctl_csb = 1'b1;
  logic ctl_sck = 1'b1;
  logic ctl_sdio_i = 1'b0;
  logic ctl_sdio_o;
  logic ctl_sdio_oe;

  int tests = 0;
  int fails = 0;
  bit model_on = 1'b0;
  bit saw_oe = 1'b0;

  always #10 clk = ~clk;

  tw_ctl_slave dut (
    .clk(clk), .pwrdn_n(pwrdn_n), .ctl_csb(ctl_csb), .ctl_sck(ctl_sck),
    .ctl_sdio_i(ctl_sdio_i), .ctl_sdio_o(ctl_sdio_o), .ctl_sdio_oe(ctl_sdio_oe)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  mmem [128];
  logic [2:0]  s1, s2, lastp;    // {data, select, clock}
  int          mcnt;
  logic [15:0] mfr;
  logic        moe, mo;
  logic [7:0]  mbuf;

  function automatic bit readable(input int a);
    return (a <= 'h19) || (a >= 'h1C && a <= 'h25) || (a == 'h30) ||
           (a >= 'h32 && a <= 'h4F);
  endfunction

  always @(posedge clk) begin
    if (!pwrdn_n) begin
      for (int i = 0; i < 128; i++) mmem[i] = (i == 0) ? 8'h01 : 8'h00;
      s1 = 3'b011; s2 = 3'b011; lastp = 3'b011;
      mcnt = 0; mfr = '0; moe = 0; mo = 0; mbuf = '0;
    end else begin
      if (s2[1] && !lastp[1]) begin
        if (mcnt == 16 && mfr[15]) mmem[mfr[14:8]] = mfr[7:0];
        mcnt = 0; moe = 0; mo = 0;
      end else if (s2[1]) begin
        mcnt = 0; moe = 0;
      end else begin
        if (s2[0] && !lastp[0]) begin
          mfr = {mfr[14:0], s2[2]};
          if (mcnt < 17) mcnt++;
        end
        if (!s2[0] && lastp[0]) begin
          if (mcnt == 8 && !mfr[7] && mmem[0][0]) begin
            logic [7:0] b;
            b = readable(int'(mfr[6:0])) ? mmem[mfr[6:0]] : 8'h00;
            moe = 1; mo = b[7]; mbuf = {b[6:0], 1'b0};
          end else if (moe) begin
            mo = mbuf[7]; mbuf = {mbuf[6:0], 1'b0};
          end
        end
      end
      lastp = s2; s2 = s1; s1 = {ctl_sdio_i, ctl_csb, ctl_sck};
    end
  end

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (ctl_sdio_oe === 1'b1) saw_oe = 1'b1;
    if (model_on) begin
      tests++;
      if (ctl_sdio_oe !== moe) begin
        fails++;
        $display("FAIL R7 per-cycle enable: actual %b expected %b at %0t", ctl_sdio_oe, moe, $time);
      end else if (moe && ctl_sdio_o !== mo) begin
        fails++;
        $display("FAIL R5 per-cycle data: actual %b expected %b at %0t", ctl_sdio_o, mo, $time);
      end
    end
  end

  // ---------------- host side ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, input bit lat_chk, output logic [7:0] got);
    logic [15:0] bits;
    bits = {wr, a, d};
    got = '0;
    saw_oe = 1'b0;
    @(negedge clk); ctl_csb = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ctl_sck = 1'b0;
      ctl_sdio_i = (i < 16) ? bits[15-i] : 1'b0;
      for (int j = 1; j <= 5; j++) begin
        @(negedge clk);
        if (lat_chk && i == 8 && j == 2) chk("R10 enable still low two cycles after turnaround edge", {7'd0, ctl_sdio_oe}, 8'h00);
        if (lat_chk && i == 8 && j == 3) chk("R10 enable high three edges after turnaround edge", {7'd0, ctl_sdio_oe}, 8'h01);
      end
      if (i >= 8 && i < 16) got[15-i] = ctl_sdio_o;
      ctl_sck = 1'b1;
      repeat (5) @(negedge clk);
    end
    ctl_csb = 1'b1;
    ctl_sdio_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] g;
    xfer(1'b1, a, d, 16, 1'b0, g);
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [7:0] g);
    xfer(1'b0, a, 8'h00, 16, 1'b0, g);
  endtask

  task automatic power_down();
    @(negedge clk); pwrdn_n = 1'b0;
    repeat (5) @(negedge clk);
    pwrdn_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : script
    logic [7:0] g;
    repeat (5) @(negedge clk);
    pwrdn_n = 1'b1;
    @(negedge clk);
    model_on = 1'b1;
    chk("R9 enable low after power-down", {7'd0, ctl_sdio_oe}, 8'h00);

    // R9 / R5: default of the read-enable register, with the turnaround timing (R10)
    xfer(1'b0, 7'h00, 8'h00, 16, 1'b1, g);
    chk("R9 default of register 00h", g, 8'h01);

    // R1 R2 R3: write then read back
    wr_reg(7'h05, 8'hA5);
    chk("R2 no drive during write frame", {7'd0, saw_oe}, 8'h00);
    rd_reg(7'h05, g);  chk("R3 readback 05h", g, 8'hA5);
    wr_reg(7'h4F, 8'h3C); rd_reg(7'h4F, g); chk("R8 top of map 4Fh", g, 8'h3C);
    wr_reg(7'h1C, 8'hC3); rd_reg(7'h1C, g); chk("R8 1Ch readable", g, 8'hC3);
    wr_reg(7'h30, 8'h5A); rd_reg(7'h30, g); chk("R8 30h readable", g, 8'h5A);
    wr_reg(7'h41, 8'h81); rd_reg(7'h41, g); chk("R1 bit order 41h", g, 8'h81);

    // R8: holes read as zero
    wr_reg(7'h1A, 8'hFF); rd_reg(7'h1A, g); chk("R8 hole 1Ah", g, 8'h00);
    wr_reg(7'h31, 8'hFF); rd_reg(7'h31, g); chk("R8 hole 31h", g, 8'h00);
    wr_reg(7'h50, 8'hFF); rd_reg(7'h50, g); chk("R8 hole 50h", g, 8'h00);

    // R4: short and long frames are discarded
    xfer(1'b1, 7'h05, 8'h11, 12, 1'b0, g);
    rd_reg(7'h05, g); chk("R4 short frame discarded", g, 8'hA5);
    xfer(1'b1, 7'h05, 8'h22, 17, 1'b0, g);
    rd_reg(7'h05, g); chk("R4 long frame discarded", g, 8'hA5);

    // R11: frame after an abort starts from bit 0
    xfer(1'b1, 7'h06, 8'h33, 5, 1'b0, g);
    wr_reg(7'h06, 8'h77); rd_reg(7'h06, g); chk("R11 decode after abort", g, 8'h77);

    // R6: read gate off, then on
    wr_reg(7'h00, 8'h00);
    rd_reg(7'h05, g);
    chk("R6 no drive with reads disabled", {7'd0, saw_oe}, 8'h00);
    wr_reg(7'h00, 8'h01);
    rd_reg(7'h05, g); chk("R6 reads restored", g, 8'hA5);

    // R7: undriven after release
    chk("R7 enable low after release", {7'd0, ctl_sdio_oe}, 8'h00);

    // R9: power-down restores defaults
    power_down();
    rd_reg(7'h05, g); chk("R9 05h back to default", g, 8'h00);
    rd_reg(7'h00, g); chk("R9 00h back to default", g, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule